// File: doc/BRIEF.md
# Time-Slot Interchange Switching Core

This block is the switching heart of a non-blocking time-slot interchange. A serial front end, which is not part of this block, hands it one parallel byte at a time. Each byte comes with the index of its input stream and channel. The block stores that byte in a data memory.

A connection memory holds one entry for each output stream and channel. Each entry carries a 3-bit mode and an 8-bit low word. Depending on the mode, the entry either names the input slot to copy from or carries a byte supplied by the processor. Configuration writes go into a staging copy, and that copy is committed on the frame pulse.

The output side asks for one output slot per request. One cycle later the block returns the byte for that slot and an output-enable. The byte depends on the slot's mode:

- Variable delay returns the freshest copy of the source slot.
- Constant delay returns the copy from two frames earlier. It reads from a data memory of three frame buffers that rotate on each frame pulse.
- Processor mode returns a fixed byte.
- BER mode returns the next byte of a PRBS-15 sequence.
- High impedance disables the slot.

Top module: `tsi_switch`

## Requirements
- R1: After synchronous active-low reset, out_valid, out_en and out_byte are 0. Every connection entry is mode 000 with low word 0, so any requested slot returns the variable-delay copy of input slot (stream 0, channel 0). That copy is 0 until it is written.
- R2: A request (out_req high with out_stream/out_chan) in cycle t produces out_valid high with out_byte/out_en in cycle t+1. Without a request, out_valid is low in the next cycle.
- R3: Mode 000 (variable delay) returns the most recent byte written for the source slot by any earlier cycle's input write, with out_en=1. The source slot is encoded in the low word as {stream, channel}: the channel is in the low CH_W bits and the stream in the next ST_W bits, so bits [4:0] and [6:5] by default.
- R4: Several output slots may name the same source slot, and each of them returns the same byte.
- R5: Mode 001 (constant delay) returns the byte written to the source slot in the frame two frame pulses before the current one, with out_en=1. A slot not written in that frame returns what the buffer last held (0 after reset).
- R6: Mode 100 (processor) returns the entry's low word as out_byte, with out_en=1, in every frame until the entry is rewritten.
- R7: Mode 101 (BER) returns the next 8 bits of a PRBS-15 generator with out_en=1. The generator is seeded to all ones and steps with new = s[14]^s[13], s = {s[13:0], new}. The first new bit of each byte lands in bit 7. The generator advances only on BER-mode requests.
- R8: Mode 111 returns out_en=0 and out_byte=0 for that slot only.
- R9: Modes 010, 011 and 110 return out_byte=8'hFF with out_en=1.
- R10: A connection write changes a slot's behaviour only after the next frame pulse that follows the cycle of the write. A write made in the same cycle as a frame pulse takes effect at the pulse after that one.
- R11: An input write made in the same cycle as a frame pulse belongs to the frame that is ending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_pulse | input | 1 | One-cycle frame boundary marker |
| in_valid | input | 1 | Input byte write strobe |
| in_stream | input | ST_W | Input stream index |
| in_chan | input | CH_W | Input channel index |
| in_byte | input | 8 | Input channel byte |
| cpu_wr | input | 1 | Connection entry write strobe |
| cpu_stream | input | ST_W | Output stream of the entry |
| cpu_chan | input | CH_W | Output channel of the entry |
| cpu_mode | input | 3 | Per-slot mode code |
| cpu_low | input | 8 | Source slot address or processor byte |
| out_req | input | 1 | Output slot request |
| out_stream | input | ST_W | Requested output stream |
| out_chan | input | CH_W | Requested output channel |
| out_valid | output | 1 | Result valid, one cycle after request |
| out_byte | output | 8 | Output slot byte |
| out_en | output | 1 | Output slot drive enable |

## Verification
The bench checks constant delay across several frame pulses. A buffer rotation that is off by one frame would return the byte from one frame too early or too late, or a stale zero.

The bench also checks timing at the frame edge:
- It places a connection write in the frame-pulse cycle. A design that committed this write early would switch the slot one frame too soon.
- It places an input write in the frame-pulse cycle. A design that filed it under the new frame would return the older byte two frames later.

For the PRBS, the bench interleaves BER and non-BER requests, so a generator that stepped on every request would skip bytes. A hard-coded check at 0xFF detects a fill code that leaked into the high-impedance slot.

// File: rtl/tsi_pkg.sv
// Package: shared widths, mode codes and connection entry type for the
// time-slot interchange core. Assumes byte-wide channels.
package tsi_pkg;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 3;

    localparam logic [MODE_W-1:0] MODE_VAR   = 3'b000;
    localparam logic [MODE_W-1:0] MODE_CONST = 3'b001;
    localparam logic [MODE_W-1:0] MODE_PROC  = 3'b100;
    localparam logic [MODE_W-1:0] MODE_BER   = 3'b101;
    localparam logic [MODE_W-1:0] MODE_HIZ   = 3'b111;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [BYTE_W-1:0] low;
    } conn_t;
endpackage

// File: rtl/tsi_data_mem.sv
// Data memory: three frame buffers that rotate on each frame pulse, plus a
// "latest copy" array for variable delay. The constant-delay read port
// returns the buffer two frames behind the write buffer. Reads are
// combinational; the caller registers them. An input write in the pulse
// cycle goes to the buffer of the frame that is ending.
module tsi_data_mem #(
    parameter int SLOTS  = 128,
    parameter int SLOT_W = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_pulse,
    input  logic                       wr_en,
    input  logic [SLOT_W-1:0]          wr_slot,
    input  logic [tsi_pkg::BYTE_W-1:0] wr_byte,
    input  logic [SLOT_W-1:0]          rd_slot,
    output logic [tsi_pkg::BYTE_W-1:0] var_byte,
    output logic [tsi_pkg::BYTE_W-1:0] const_byte,
    output logic [1:0]                 wr_buf
);
    localparam int NBUF = 3;

    logic [tsi_pkg::BYTE_W-1:0] frame_q  [NBUF][SLOTS];
    logic [tsi_pkg::BYTE_W-1:0] latest_q [SLOTS];
    logic [1:0] rd_buf;

    // Frame buffer index: modulo-3 counter stepped by the frame pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)           wr_buf <= 2'd0;
        else if (frame_pulse) wr_buf <= (wr_buf == 2'd2) ? 2'd0 : wr_buf + 2'd1;
    end

    // Store each input byte into the current frame buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < NBUF; b++)
                for (int s = 0; s < SLOTS; s++)
                    frame_q[b][s] <= '0;
        end else if (wr_en) begin
            frame_q[wr_buf][wr_slot] <= wr_byte;
        end
    end

    // Keep the freshest copy of each input slot for variable delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) latest_q[s] <= '0;
        end else if (wr_en) begin
            latest_q[wr_slot] <= wr_byte;
        end
    end

    // Constant-delay reads use the buffer two frames behind (i.e. one ahead mod 3).
    always_comb begin
        rd_buf     = (wr_buf == 2'd2) ? 2'd0 : wr_buf + 2'd1;
        const_byte = frame_q[rd_buf][rd_slot];
        var_byte   = latest_q[rd_slot];
    end
endmodule

// File: rtl/tsi_conn_mem.sv
// Connection memory: a staging copy written by the processor port and an
// active copy that the output path reads. The staging copy is copied into
// the active copy on each frame pulse, so configuration changes only at
// frame boundaries. A write in the pulse cycle misses that pulse's copy.
module tsi_conn_mem #(
    parameter int SLOTS  = 128,
    parameter int SLOT_W = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_pulse,
    input  logic                  wr_en,
    input  logic [SLOT_W-1:0]     wr_slot,
    input  tsi_pkg::conn_t        wr_entry,
    input  logic [SLOT_W-1:0]     rd_slot,
    output tsi_pkg::conn_t        rd_entry
);
    tsi_pkg::conn_t stage_q  [SLOTS];
    tsi_pkg::conn_t active_q [SLOTS];

    // Capture processor writes into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) stage_q[s] <= '0;
        end else if (wr_en) begin
            stage_q[wr_slot] <= wr_entry;
        end
    end

    // Commit the staging copy to the active copy at each frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) active_q[s] <= '0;
        end else if (frame_pulse) begin
            for (int s = 0; s < SLOTS; s++) active_q[s] <= stage_q[s];
        end
    end

    // Read the active entry for the requested output slot.
    always_comb rd_entry = active_q[rd_slot];
endmodule

// File: rtl/tsi_prbs.sv
// PRBS-15 byte source for BER slots. Seeded to all ones; each advance makes
// eight steps of new = s[14]^s[13], s = {s[13:0], new}. The first new bit
// lands in byte bit 7. The state holds when adv is low.
module tsi_prbs #(
    parameter int PRBS_W = 15
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       adv,
    output logic [tsi_pkg::BYTE_W-1:0] next_byte,
    output logic [PRBS_W-1:0]          state
);
    logic [PRBS_W-1:0] nxt_state;

    // Unroll eight generator steps to form the next byte and next state.
    always_comb begin
        logic nb;
        nxt_state = state;
        next_byte = '0;
        for (int i = 0; i < tsi_pkg::BYTE_W; i++) begin
            nb = nxt_state[PRBS_W-1] ^ nxt_state[PRBS_W-2];
            nxt_state = {nxt_state[PRBS_W-2:0], nb};
            next_byte[tsi_pkg::BYTE_W-1-i] = nb;
        end
    end

    // Advance the generator only on BER-mode requests.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= '1;
        else if (adv) state <= nxt_state;
    end
endmodule

// File: rtl/tsi_switch.sv
// Top of the time-slot interchange core. Input bytes fill the data memory.
// Each output request looks up its active connection entry and returns one
// byte plus an enable, registered one cycle later, chosen by the slot mode.
// Assumes ST_W+CH_W fits in the 8-bit connection low word.
module tsi_switch #(
    parameter int NUM_STREAMS  = 4,
    parameter int NUM_CHANNELS = 32,
    parameter int ST_W = $clog2(NUM_STREAMS),
    parameter int CH_W = $clog2(NUM_CHANNELS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       frame_pulse,
    input  logic                       in_valid,
    input  logic [ST_W-1:0]            in_stream,
    input  logic [CH_W-1:0]            in_chan,
    input  logic [tsi_pkg::BYTE_W-1:0] in_byte,
    input  logic                       cpu_wr,
    input  logic [ST_W-1:0]            cpu_stream,
    input  logic [CH_W-1:0]            cpu_chan,
    input  logic [tsi_pkg::MODE_W-1:0] cpu_mode,
    input  logic [tsi_pkg::BYTE_W-1:0] cpu_low,
    input  logic                       out_req,
    input  logic [ST_W-1:0]            out_stream,
    input  logic [CH_W-1:0]            out_chan,
    output logic                       out_valid,
    output logic [tsi_pkg::BYTE_W-1:0] out_byte,
    output logic                       out_en
);
    import tsi_pkg::*;

    localparam int SLOT_W = ST_W + CH_W;
    localparam int SLOTS  = NUM_STREAMS * NUM_CHANNELS;

    conn_t                 act_entry;
    logic [MODE_W-1:0]     act_mode;
    logic [BYTE_W-1:0]     act_low;
    logic [BYTE_W-1:0]     var_byte;
    logic [BYTE_W-1:0]     const_byte;
    logic [BYTE_W-1:0]     prbs_byte;
    logic [14:0]           prbs_state;
    logic [1:0]            wr_buf;
    logic                  prbs_adv;
    conn_t                 cpu_entry;

    // Split the active entry and build the write entry.
    always_comb begin
        act_mode  = act_entry.mode;
        act_low   = act_entry.low;
        cpu_entry = '{mode: cpu_mode, low: cpu_low};
        prbs_adv  = out_req && (act_mode == MODE_BER);
    end

    tsi_data_mem #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_pulse(frame_pulse),
        .wr_en      (in_valid),
        .wr_slot    ({in_stream, in_chan}),
        .wr_byte    (in_byte),
        .rd_slot    (act_low[SLOT_W-1:0]),
        .var_byte   (var_byte),
        .const_byte (const_byte),
        .wr_buf     (wr_buf)
    );

    tsi_conn_mem #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_conn (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_pulse(frame_pulse),
        .wr_en      (cpu_wr),
        .wr_slot    ({cpu_stream, cpu_chan}),
        .wr_entry   (cpu_entry),
        .rd_slot    ({out_stream, out_chan}),
        .rd_entry   (act_entry)
    );

    tsi_prbs #(.PRBS_W(15)) u_prbs (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (prbs_adv),
        .next_byte(prbs_byte),
        .state    (prbs_state)
    );

    // Register the requested slot's byte and enable according to its mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_byte  <= '0;
            out_en    <= 1'b0;
        end else begin
            out_valid <= out_req;
            out_byte  <= '0;
            out_en    <= 1'b0;
            if (out_req) begin
                out_en <= 1'b1;
                case (act_mode)
                    MODE_VAR:   out_byte <= var_byte;
                    MODE_CONST: out_byte <= const_byte;
                    MODE_PROC:  out_byte <= act_low;
                    MODE_BER:   out_byte <= prbs_byte;
                    MODE_HIZ: begin
                        out_byte <= '0;
                        out_en   <= 1'b0;
                    end
                    default:    out_byte <= '1;
                endcase
            end
        end
    end
endmodule

// File: rtl/tsi_switch_chk.sv
// Checker for tsi_switch: protocol and mode properties, bound to the top.
module tsi_switch_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        out_req,
    input logic        out_valid,
    input logic [7:0]  out_byte,
    input logic        out_en,
    input logic        frame_pulse,
    input logic [2:0]  act_mode,
    input logic [7:0]  act_low,
    input logic [1:0]  wr_buf,
    input logic [14:0] prbs_state
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_req |=> out_valid);                                        // R2
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !out_req |=> !out_valid);                                      // R2
    AST_HIZ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && act_mode == 3'b111) |=> (!out_en && out_byte == 8'h00)); // R8
    AST_PROC_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && act_mode == 3'b100) |=> (out_en && out_byte == $past(act_low))); // R6
    AST_FILL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_req && (act_mode == 3'b010 || act_mode == 3'b011 || act_mode == 3'b110))
        |=> (out_en && out_byte == 8'hFF));                            // R9
    AST_BUF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_buf != 2'd3);                                               // R5
    AST_BUF_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |=> (wr_buf == (($past(wr_buf) == 2'd2) ? 2'd0 : $past(wr_buf) + 2'd1))); // R5
    AST_PRBS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_req && act_mode == 3'b101) |=> $stable(prbs_state));     // R7
    AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        prbs_state != 15'd0);                                          // R7
endmodule

bind tsi_switch tsi_switch_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_req    (out_req),
    .out_valid  (out_valid),
    .out_byte   (out_byte),
    .out_en     (out_en),
    .frame_pulse(frame_pulse),
    .act_mode   (act_mode),
    .act_low    (act_low),
    .wr_buf     (wr_buf),
    .prbs_state (prbs_state)
);

// File: tb/tb_tsi_switch.sv
`timescale 1ns/1ps
// Bench for tsi_switch: a vector table after a fixed configuration, then
// directed frame-rotation, BER and frame-edge tests.
module tb_tsi_switch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_pulse = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] in_stream = '0;
    logic [4:0] in_chan = '0;
    logic [7:0] in_byte = '0;
    logic       cpu_wr = 1'b0;
    logic [1:0] cpu_stream = '0;
    logic [4:0] cpu_chan = '0;
    logic [2:0] cpu_mode = '0;
    logic [7:0] cpu_low = '0;
    logic       out_req = 1'b0;
    logic [1:0] out_stream = '0;
    logic [4:0] out_chan = '0;
    logic       out_valid;
    logic [7:0] out_byte;
    logic       out_en;

    int n_chk = 0;
    int n_fail = 0;
    logic [14:0] prbs_m = '1;

    // {stream, channel, expected byte, expected enable}
    localparam logic [15:0] VEC [6] = '{
        {2'd0, 5'd0,  8'h3C, 1'b1},   // R3 variable delay
        {2'd0, 5'd1,  8'h3C, 1'b1},   // R4 multicast of same source
        {2'd1, 5'd5,  8'h00, 1'b1},   // R5 constant delay, buffer still empty
        {2'd2, 5'd2,  8'hA5, 1'b1},   // R6 processor byte
        {2'd3, 5'd31, 8'h00, 1'b0},   // R8 high impedance
        {2'd3, 5'd0,  8'hFF, 1'b1}    // R9 unlisted code fill
    };
    string vec_tag [6] = '{"R3", "R4", "R5", "R6", "R8", "R9"};

    tsi_switch dut (.*);

    always #2.5 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic check(string tag, logic [7:0] ab, logic ae, logic [7:0] eb, logic ee);
        n_chk++;
        if (ab !== eb || ae !== ee) begin
            n_fail++;
            $display("FAIL %s: actual byte=%h en=%b, expected byte=%h en=%b", tag, ab, ae, eb, ee);
        end
    endtask

    task automatic request(input logic [1:0] s, input logic [4:0] c, string tag,
                           input logic [7:0] eb, input logic ee);
        @(negedge clk);
        out_req = 1'b1; out_stream = s; out_chan = c;
        @(negedge clk);
        out_req = 1'b0;
        n_chk++;
        if (out_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R2: actual out_valid=%b expected 1", out_valid);
        end
        check(tag, out_byte, out_en, eb, ee);
    endtask

    task automatic cpu_write(input logic [1:0] s, input logic [4:0] c,
                             input logic [2:0] m, input logic [7:0] lo);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_stream = s; cpu_chan = c; cpu_mode = m; cpu_low = lo;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic in_write(input logic [1:0] s, input logic [4:0] c, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_stream = s; in_chan = c; in_byte = b;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        frame_pulse = 1'b1;
        @(negedge clk);
        frame_pulse = 1'b0;
    endtask

    // Model of the BER byte source from R7.
    function automatic logic [7:0] prbs_next();
        logic [7:0] b = '0;
        for (int i = 0; i < 8; i++) begin
            logic nb = prbs_m[14] ^ prbs_m[13];
            prbs_m = {prbs_m[13:0], nb};
            b[7-i] = nb;
        end
        return b;
    endfunction

    initial begin
        // R1: outputs held at zero in reset
        repeat (3) @(negedge clk);
        check("R1", out_byte, out_en, 8'h00, 1'b0);
        n_chk++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual out_valid=%b expected 0", out_valid);
        end
        rst_n = 1'b1;
        // R1: default entry is variable delay from slot (0,0), still zero
        request(2'd3, 5'd9, "R1", 8'h00, 1'b1);

        // Configuration, staged until the next frame pulse
        cpu_write(2'd0, 5'd0,  3'b000, 8'h23);
        cpu_write(2'd0, 5'd1,  3'b000, 8'h23);
        cpu_write(2'd1, 5'd6,  3'b000, 8'h47);
        cpu_write(2'd1, 5'd5,  3'b001, 8'h47);
        cpu_write(2'd2, 5'd2,  3'b100, 8'hA5);
        cpu_write(2'd3, 5'd31, 3'b111, 8'h00);
        cpu_write(2'd3, 5'd0,  3'b010, 8'h00);
        cpu_write(2'd2, 5'd9,  3'b101, 8'h00);
        // R10: not active before the frame pulse
        request(2'd2, 5'd2, "R10", 8'h00, 1'b1);
        pulse();                                    // buffer index now 1

        in_write(2'd1, 5'd3, 8'h3C);
        in_write(2'd2, 5'd7, 8'h11);
        for (int i = 0; i < 6; i++)
            request(VEC[i][15:14], VEC[i][13:9], vec_tag[i], VEC[i][8:1], VEC[i][0]);

        pulse();                                    // index 2
        request(2'd1, 5'd5, "R5", 8'h00, 1'b1);
        in_write(2'd2, 5'd7, 8'h22);
        request(2'd1, 5'd6, "R3", 8'h22, 1'b1);     // R3 freshest copy
        pulse();                                    // index 0
        request(2'd1, 5'd5, "R5", 8'h11, 1'b1);     // R5 two frames back
        pulse();                                    // index 1
        request(2'd1, 5'd5, "R5", 8'h22, 1'b1);

        // R7: PRBS advances only on BER slots
        request(2'd2, 5'd9, "R7", prbs_next(), 1'b1);
        request(2'd3, 5'd0, "R9", 8'hFF, 1'b1);
        request(2'd2, 5'd9, "R7", prbs_next(), 1'b1);
        request(2'd2, 5'd9, "R7", prbs_next(), 1'b1);

        // R10 and R11: writes in the frame-pulse cycle
        @(negedge clk);
        frame_pulse = 1'b1;
        in_valid = 1'b1; in_stream = 2'd2; in_chan = 5'd7; in_byte = 8'h77;
        cpu_wr = 1'b1; cpu_stream = 2'd2; cpu_chan = 5'd2; cpu_mode = 3'b100; cpu_low = 8'h5A;
        @(negedge clk);
        frame_pulse = 1'b0; in_valid = 1'b0; cpu_wr = 1'b0;   // index 2
        request(2'd2, 5'd2, "R10", 8'hA5, 1'b1);
        request(2'd1, 5'd5, "R5", 8'h00, 1'b1);
        pulse();                                    // index 0
        request(2'd1, 5'd5, "R11", 8'h77, 1'b1);
        request(2'd2, 5'd2, "R10", 8'h5A, 1'b1);
        request(2'd1, 5'd6, "R3", 8'h77, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule